// File: doc/BRIEF.md
# DMA Channel Interrupt Cause Controller

This block gathers the interrupt sources of a DMA transfer/event channel pair into one sticky status word, masks it with a per-source enable word and turns the result into an interrupt toward the processor. Software sees four registers at fixed offsets. There is a read-only status word, a write-ones clear word, an enable word and a small interrupt-control word. The low bit of the control word picks between a wired level interrupt and a message-style single-cycle pulse.

The source bits sit at fixed, non-contiguous positions. Bit 0 is the normal end-of-block completion. Bits 1, 9, 10, 11 and 14 are error causes. Bit 15 reports that a channel reset has finished. A separate backlog input tells the block that completed event records are still waiting to be consumed. While that input is high, the completion cause cannot stay cleared, so the interrupt keeps firing until software has drained the ring.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After reset the status, enable and control words read as zero, and irq_level_o, irq_pulse_o and irq_err_o are low.
- R2: A high src_evt_i bit at an implemented position (0, 1, 9, 10, 11, 14, 15) sets the matching status bit (offset 0x100) at the next clock edge. The bit stays set until it is cleared. src_evt_i bits at any other position are ignored and read as zero.
- R3: Writing to the clear word (offset 0x108) clears exactly the status bits written as one and leaves the others. The clear word reads as zero.
- R4: If a source event and a clear of the same bit arrive in the same cycle, the event wins and the status bit stays set.
- R5: While evt_backlog_i is high, status bit 0 is set every cycle, so a clear of bit 0 does not stick.
- R6: The enable word (offset 0x110) stores only the implemented positions and reads back as the written value ANDed with 0x0000CE03. The active cause is status AND enable. A pending but disabled bit raises no output.
- R7: The control word (offset 0x004) stores bits 3:0 and reads zero above them. Bit 0 = 1 selects wired mode and bit 0 = 0 selects message mode.
- R8: In wired mode irq_level_o equals the OR of the active cause, registered, one edge after status or enable changes. It is always low in message mode.
- R9: In message mode irq_pulse_o is high for exactly one cycle, one edge after any cause bit goes from 0 to 1. A cause bit that stays high gives no further pulse. irq_pulse_o is always low in wired mode.
- R10: irq_err_o is the registered OR of the active cause over the error group, mask 0x00004E02 (bits 1, 9, 10, 11, 14), in either mode. Bits 0 and 15 never raise it.
- R11: Writes to the status offset or to any unmapped offset change no register.
- R12: Bit 15 is the reset-done cause. It is set by src_evt_i[15] and cleared only by software through the clear word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from reg_addr_i |
| src_evt_i | input | 32 | Per-position source event strobes |
| evt_backlog_i | input | 1 | Completed event records still unconsumed |
| irq_level_o | output | 1 | Wired-mode interrupt level |
| irq_pulse_o | output | 1 | Message-mode interrupt pulse |
| irq_err_o | output | 1 | Error-group cause pending |

## Verification
Status, enable and control words change at the edge that samples the event or write. The read port is combinational, so the bench reads them back at the falling edge right after that edge. The three interrupt outputs pass through one more register. The bench therefore waits one further falling edge before it samples them, and for the pulse it samples one edge later still to confirm that the pulse has dropped. Inputs are driven and outputs sampled only on falling edges, so every expected value falls at a fixed edge count from its stimulus.

// File: rtl/dma_irq_pkg.sv
// Package: register offsets, source bit positions and derived masks for the
// DMA channel interrupt cause controller. Assumes a 32-bit register word.
package dma_irq_pkg;
    localparam int SRC_W = 32;

    localparam logic [11:0] OFF_INTCTL = 12'h004;
    localparam logic [11:0] OFF_STATUS = 12'h100;
    localparam logic [11:0] OFF_CLEAR  = 12'h108;
    localparam logic [11:0] OFF_ENABLE = 12'h110;

    localparam int POS_EOB       = 0;
    localparam int POS_EVWR_ERR  = 1;
    localparam int POS_DRD_ERR   = 9;
    localparam int POS_DATRD_ERR = 10;
    localparam int POS_DATWR_ERR = 11;
    localparam int POS_BAD_DESC  = 14;
    localparam int POS_RST_DONE  = 15;

    // Build the mask of error-group positions.
    function automatic logic [SRC_W-1:0] err_mask_f();
        logic [SRC_W-1:0] m;
        m = '0;
        m[POS_EVWR_ERR]  = 1'b1;
        m[POS_DRD_ERR]   = 1'b1;
        m[POS_DATRD_ERR] = 1'b1;
        m[POS_DATWR_ERR] = 1'b1;
        m[POS_BAD_DESC]  = 1'b1;
        return m;
    endfunction

    // Build the mask of every implemented position.
    function automatic logic [SRC_W-1:0] impl_mask_f();
        logic [SRC_W-1:0] m;
        m = err_mask_f();
        m[POS_EOB]      = 1'b1;
        m[POS_RST_DONE] = 1'b1;
        return m;
    endfunction

    localparam logic [SRC_W-1:0] ERR_MASK  = err_mask_f();
    localparam logic [SRC_W-1:0] IMPL_MASK = impl_mask_f();
endpackage

// File: rtl/dma_irq_regs.sv
// Register file: decodes writes to the enable, control and clear offsets and
// muxes read data. Assumes a single-cycle write strobe; reads are combinational.
module dma_irq_regs
    import dma_irq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int MODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [SRC_W-1:0]  wdata_i,
    input  logic [SRC_W-1:0]  status_i,
    output logic [SRC_W-1:0]  enable_o,
    output logic [SRC_W-1:0]  clr_o,
    output logic              wired_o,
    output logic [SRC_W-1:0]  rdata_o
);
    localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(OFF_INTCTL);
    localparam logic [ADDR_W-1:0] A_ST  = ADDR_W'(OFF_STATUS);
    localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(OFF_ENABLE);
    localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(OFF_CLEAR);

    logic [SRC_W-1:0]  enable_q;
    logic [MODE_W-1:0] mode_q;
    logic              wr_en, wr_ctl, wr_clr;

    // Decode write strobes per offset.
    always_comb begin
        wr_en  = we_i && (addr_i == A_EN);
        wr_ctl = we_i && (addr_i == A_CTL);
        wr_clr = we_i && (addr_i == A_CLR);
    end

    // Enable word holds only implemented positions.
    always_ff @(posedge clk) begin
        if (!rst_n)      enable_q <= '0;
        else if (wr_en)  enable_q <= wdata_i & IMPL_MASK;
    end

    // Interrupt-control word keeps the low mode bits.
    always_ff @(posedge clk) begin
        if (!rst_n)      mode_q <= '0;
        else if (wr_ctl) mode_q <= wdata_i[MODE_W-1:0];
    end

    // Clear strobe vector toward the status bank.
    always_comb clr_o = wr_clr ? (wdata_i & IMPL_MASK) : '0;

    // Read mux; clear word and unmapped offsets read zero.
    always_comb begin
        rdata_o = '0;
        if (addr_i == A_ST)       rdata_o = status_i;
        else if (addr_i == A_EN)  rdata_o = enable_q;
        else if (addr_i == A_CTL) rdata_o = SRC_W'(mode_q);
    end

    assign enable_o = enable_q;
    assign wired_o  = mode_q[0];

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_i && addr_i == A_CTL) |=> $stable(mode_q)); // R7
    AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_i && addr_i == A_EN) |=> $stable(enable_q)); // R11
endmodule

// File: rtl/dma_irq_status.sv
// Sticky status bank: one flop per implemented source position, set by its
// event (or by the backlog input for end-of-block), cleared by the clear
// strobe; set wins. Unimplemented positions are tied to zero.
module dma_irq_status
    import dma_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] src_i,
    input  logic             backlog_i,
    input  logic [SRC_W-1:0] clr_i,
    output logic [SRC_W-1:0] status_o
);
    logic [SRC_W-1:0] set_vec;

    // Merge the backlog into the end-of-block set term.
    always_comb begin
        set_vec = src_i & IMPL_MASK;
        set_vec[POS_EOB] = src_i[POS_EOB] | backlog_i;
    end

    for (genvar i = 0; i < SRC_W; i++) begin : g_bit
        if (IMPL_MASK[i]) begin : g_impl
            logic q;
            // Sticky bit: set has priority over clear.
            always_ff @(posedge clk) begin
                if (!rst_n)          q <= 1'b0;
                else if (set_vec[i]) q <= 1'b1;
                else if (clr_i[i])   q <= 1'b0;
            end
            assign status_o[i] = q;
        end else begin : g_none
            assign status_o[i] = 1'b0;
        end
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i[POS_DATRD_ERR] && clr_i[POS_DATRD_ERR]) |=> status_o[POS_DATRD_ERR]); // R4
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i[POS_RST_DONE] && !src_i[POS_RST_DONE]) |=> !status_o[POS_RST_DONE]); // R3
    AST_BACKLOG_REFIRE: assert property (@(posedge clk) disable iff (!rst_n)
        backlog_i |=> status_o[POS_EOB]); // R5
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_o & $past(status_o & ~clr_i)) == $past(status_o & ~clr_i))); // R2
    AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o & ~IMPL_MASK) == '0); // R2
endmodule

// File: rtl/dma_irq_out.sv
// Output stage: forms the active cause (status AND enable) and registers the
// wired level, the message pulse on a newly rising cause, and the error flag.
module dma_irq_out
    import dma_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] status_i,
    input  logic [SRC_W-1:0] enable_i,
    input  logic             wired_i,
    output logic             level_o,
    output logic             pulse_o,
    output logic             err_o
);
    logic [SRC_W-1:0] cause, cause_q;

    // Active cause.
    always_comb cause = status_i & enable_i;

    // Previous-cycle cause for rising detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cause_q <= '0;
        else        cause_q <= cause;
    end

    // Registered interrupt outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_o <= 1'b0;
            pulse_o <= 1'b0;
            err_o   <= 1'b0;
        end else begin
            level_o <= wired_i && (|cause);
            pulse_o <= !wired_i && (|(cause & ~cause_q));
            err_o   <= |(cause & ERR_MASK);
        end
    end

    AST_LEVEL_WIRED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        level_o |-> $past(wired_i && (|(status_i & enable_i)))); // R8
    AST_PULSE_MSG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> $past(!wired_i)); // R9
    AST_ERR_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(|(status_i & enable_i & ERR_MASK))); // R10
    AST_EXCL_MODES: assert property (@(posedge clk) disable iff (!rst_n)
        !(level_o && pulse_o)); // R9
endmodule

// File: rtl/dma_irq_ctrl.sv
// Top: DMA channel interrupt cause controller. Connects the register file,
// the sticky status bank and the output stage. Assumes synchronous reset.
module dma_irq_ctrl
    import dma_irq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int MODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    input  logic [31:0]       src_evt_i,
    input  logic              evt_backlog_i,
    output logic              irq_level_o,
    output logic              irq_pulse_o,
    output logic              irq_err_o
);
    logic [SRC_W-1:0] status, enable, clr;
    logic             wired;

    dma_irq_regs #(.ADDR_W(ADDR_W), .MODE_W(MODE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we_i(reg_we_i), .addr_i(reg_addr_i),
        .wdata_i(reg_wdata_i), .status_i(status), .enable_o(enable),
        .clr_o(clr), .wired_o(wired), .rdata_o(reg_rdata_o)
    );

    dma_irq_status u_status (
        .clk(clk), .rst_n(rst_n), .src_i(src_evt_i), .backlog_i(evt_backlog_i),
        .clr_i(clr), .status_o(status)
    );

    dma_irq_out u_out (
        .clk(clk), .rst_n(rst_n), .status_i(status), .enable_i(enable),
        .wired_i(wired), .level_o(irq_level_o), .pulse_o(irq_pulse_o),
        .err_o(irq_err_o)
    );
endmodule

// File: tb/dma_irq_ctrl_tb.sv
module dma_irq_ctrl_tb;
    localparam logic [31:0] IMPL = 32'h0000_CE03;
    localparam logic [31:0] ERRM = 32'h0000_4E02;
    localparam logic [11:0] A_CTL = 12'h004, A_ST = 12'h100,
                            A_CLR = 12'h108, A_EN = 12'h110;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] src = '0;
    logic        backlog = 1'b0;
    logic        lvl, pls, err;
    int          checks = 0, fails = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    dma_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we_i(we), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .src_evt_i(src),
        .evt_backlog_i(backlog), .irq_level_o(lvl), .irq_pulse_o(pls),
        .irq_err_o(err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        we = 1'b1; addr = a; wdata = d;
        tick();
        we = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic evt(input logic [31:0] v);
        src = v;
        tick();
        src = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        rd(A_ST, v);  chk("R1 status", v, 0);
        rd(A_EN, v);  chk("R1 enable", v, 0);
        rd(A_CTL, v); chk("R1 ctl", v, 0);
        chk("R1 outputs", {29'd0, lvl, pls, err}, 0);

        // R2/R12 sweep of every source position, R3 clear
        for (int b = 0; b < 32; b++) begin
            evt(32'd1 << b);
            rd(A_ST, v); chk(b == 15 ? "R12 reset-done set" : "R2 set/ignore", v, (32'd1 << b) & IMPL);
            tick();
            chk("R6 disabled no irq", {31'd0, lvl | err | pls}, 0);
            rd(A_CLR, v); chk("R3 clear reads zero", v, 0);
            wr(A_CLR, 32'hFFFF_FFFF);
            rd(A_ST, v); chk("R3 clear all", v, 0);
        end

        // R6 enable readback, R7 control readback
        wr(A_EN, 32'hFFFF_FFFF);
        rd(A_EN, v); chk("R6 enable mask", v, IMPL);
        wr(A_CTL, 32'hFFFF_FFF5);
        rd(A_CTL, v); chk("R7 ctl low nibble", v, 32'h5);
        wr(A_CTL, 32'h1);

        // R8/R10 wired sweep
        for (int b = 0; b < 32; b++) begin
            if (IMPL[b]) begin
                evt(32'd1 << b);
                tick();
                chk("R8 level high", {31'd0, lvl}, 1);
                chk("R10 err group", {31'd0, err}, {31'd0, ERRM[b]});
                chk("R9 no pulse wired", {31'd0, pls}, 0);
                wr(A_CLR, 32'd1 << b);
                tick();
                chk("R8 level drops", {31'd0, lvl | err}, 0);
            end
        end

        // R6 masking
        wr(A_EN, 32'h1);
        evt(32'h200);
        tick();
        chk("R6 masked cause", {30'd0, lvl, err}, 0);
        rd(A_ST, v); chk("R6 status still pending", v, 32'h200);
        wr(A_EN, 32'h200);
        tick();
        chk("R6 enable exposes", {30'd0, lvl, err}, 2'b11);
        wr(A_CLR, 32'hFFFF_FFFF);

        // R4 set wins over clear
        we = 1'b1; addr = A_CLR; wdata = 32'h400; src = 32'h400;
        tick();
        we = 1'b0; wdata = '0; src = '0;
        rd(A_ST, v); chk("R4 set wins", v, 32'h400);
        wr(A_CLR, 32'h400);

        // R3 partial clear
        evt(32'h203);
        wr(A_CLR, 32'h2);
        rd(A_ST, v); chk("R3 partial clear", v, 32'h201);
        wr(A_CLR, 32'hFFFF_FFFF);

        // R5 backlog refire
        backlog = 1'b1;
        tick();
        wr(A_CLR, 32'h1);
        rd(A_ST, v); chk("R5 refire under backlog", v, 32'h1);
        backlog = 1'b0;
        wr(A_CLR, 32'h1);
        rd(A_ST, v); chk("R5 clear after drain", v, 0);

        // R11 ignored writes
        wr(A_EN, IMPL);
        wr(A_ST, 32'hFFFF_FFFF);
        rd(A_ST, v); chk("R11 status write ignored", v, 0);
        wr(12'h10C, 32'h0);
        wr(12'h000, 32'h0);
        rd(A_EN, v); chk("R11 enable unchanged", v, IMPL);
        rd(A_CTL, v); chk("R11 ctl unchanged", v, 32'h1);

        // R9 message mode sweep
        wr(A_CTL, 32'h0);
        for (int b = 0; b < 32; b++) begin
            if (IMPL[b]) begin
                evt(32'd1 << b);
                tick();
                chk("R9 pulse", {31'd0, pls}, 1);
                chk("R8 level low in msg", {31'd0, lvl}, 0);
                chk("R10 err in msg", {31'd0, err}, {31'd0, ERRM[b]});
                tick();
                chk("R9 pulse one cycle", {31'd0, pls}, 0);
                wr(A_CLR, 32'd1 << b);
            end
        end
        // R9 held cause gives no new pulse; a second rising bit does
        evt(32'h1);
        tick(); tick();
        evt(32'h1);
        tick();
        chk("R9 no repulse held", {31'd0, pls}, 0);
        evt(32'h2);
        tick();
        chk("R9 second rising", {31'd0, pls}, 1);
        wr(A_CLR, 32'hFFFF_FFFF);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule